// File: doc/BRIEF.md
# Descriptor Operand Address Modifier

This block turns a 64-bit operand descriptor and a signed 32-bit modifier into the byte address of the item being selected. The upper word of the descriptor gives the item kind, the item size, a scaling-disable flag, a check-disable flag and a 24-bit limit. The lower word is the base byte address. Depending on the kind and size, the modifier is scaled to a byte offset and checked against the limit, then added to the base. Bit vectors also return the bit position inside the addressed byte. Code descriptors count the modifier in half-words. Escape descriptors are flagged so that control logic can run its own sequence. Reserved or unsupported encodings are flagged and give no address.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream through one register stage. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. Back-pressure from `out_ready` therefore reaches the input in the same cycle. A result that is not taken stays unchanged on the outputs.

Top module: `opnd_addr_mod`

## Requirements
- R1: Upper-word fields, from bit 63 down, are kind (2 bits, 63:62), size code (3 bits, 61:59), a reserved bit (58), scaling-disable (57), check-disable (56) and limit (55:32). Bits 31:0 are the base. With kind 0, size code 3 and scaling disabled, the address is base plus modifier.
- R2: For kind 0 with scaling enabled (bit 57 = 0), the modifier is multiplied by 4, 8 or 16 for size codes 5, 6 or 7, which select 32-, 64- or 128-bit items. The item size output repeats the size code.
- R3: For kind 0 with size code 0 (single bits) and scaling enabled, the byte offset is the modifier shifted right arithmetically by 3, and `out_bit_off` is modifier bits 2:0. In every other case `out_bit_off` is 0.
- R4: When the check-disable bit is 0, a limit fault is reported if the unscaled modifier, read as unsigned, is greater than or equal to the limit. When the bit is 1, no fault is reported. The address is produced in both cases.
- R5: For size codes 5, 6 and 7 (kinds 0 and 2), address bits 1:0 are forced to 0 after the addition.
- R6: Kind 1 (byte string) must carry size code 3. It adds the modifier without scaling or checking, whatever the flag bits say. Any other size code with kind 1 is flagged as unsupported.
- R7: Kind 2 behaves as kind 0 with size code 6, whatever its size field holds, and reports size code 6.
- R8: Kind 3 takes its subtype from bits 61:56. Subtype 32 (checked) and subtype 34 (unchecked) are code descriptors. The address is the base with bits 1:0 cleared, plus twice the modifier, and the reported size is 5. Subtype 32 always checks the modifier against the limit.
- R9: Kind 3 subtype 37 raises `out_escape`, returns the base with bits 1:0 cleared, and never reports a limit fault.
- R10: Kind 3 subtype 35, any other kind-3 subtype not named above, and kind 0 with size code 1, 2 or 4, raise `out_trap`. Address, bit offset, size and fault are then all 0.
- R11: `in_ready` is high exactly when the output is empty or `out_ready` is high. A result appears on the outputs in the cycle after the request is taken. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R12: While `rst_n` is low, and right after it rises, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_desc | input | 64 | Operand descriptor |
| in_mod | input | 32 | Signed modifier |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Effective byte address |
| out_bit_off | output | 3 | Bit position within the byte for single-bit items |
| out_size | output | 3 | Item size code |
| out_bound_fault | output | 1 | Modifier outside the limit |
| out_escape | output | 1 | Escape descriptor seen |
| out_trap | output | 1 | Unsupported or system-call encoding |

## Verification
Each result is due exactly one clock after the edge that takes its request. The result then stays on the outputs for every further cycle that `out_ready` is low. The bench predicts each result from the request fields when the handshake is seen and places it in a queue. On every falling edge it compares `out_valid` with whether the queue holds anything, and compares the front entry field by field. The entry is removed only on a cycle where `out_ready` is high, so a stalled result is checked again on each cycle of the stall.

// File: rtl/oam_pkg.sv
package oam_pkg;
  typedef enum logic [2:0] {
    K_VEC  = 3'd0,
    K_STR  = 3'd1,
    K_CODE = 3'd2,
    K_ESC  = 3'd3,
    K_TRAP = 3'd4
  } kind_e;

  localparam logic [1:0] T_VEC  = 2'd0;
  localparam logic [1:0] T_STR  = 2'd1;
  localparam logic [1:0] T_DD   = 2'd2;
  localparam logic [1:0] T_MISC = 2'd3;

  localparam logic [2:0] SZ_BIT   = 3'd0;
  localparam logic [2:0] SZ_BYTE  = 3'd3;
  localparam logic [2:0] SZ_WORD  = 3'd5;
  localparam logic [2:0] SZ_DWORD = 3'd6;
  localparam logic [2:0] SZ_QUAD  = 3'd7;

  localparam logic [5:0] SUB_CODE_CHK = 6'd32;
  localparam logic [5:0] SUB_CODE_FREE = 6'd34;
  localparam logic [5:0] SUB_ESCAPE   = 6'd37;

  typedef struct packed {
    kind_e      kind;
    logic [2:0] size;
    logic       scale_en;
    logic       check_en;
    logic       half_mod;
    logic       align_base;
    logic       align_res;
  } ctl_t;

  function automatic logic size_legal(input logic [2:0] s);
    return (s == SZ_BIT) || (s == SZ_BYTE) || (s == SZ_WORD) ||
           (s == SZ_DWORD) || (s == SZ_QUAD);
  endfunction
endpackage

// File: rtl/oam_decode.sv
module oam_decode
  import oam_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BOUND_W = 24
) (
  input  logic [8+BOUND_W+ADDR_W-1:0] desc,
  output ctl_t                        ctl,
  output logic [BOUND_W-1:0]          bound,
  output logic [ADDR_W-1:0]           base
);
  localparam int TOP = 8 + BOUND_W + ADDR_W - 1;

  logic [1:0] kind_f;
  logic [2:0] size_f;
  logic       noscale_f;
  logic       nocheck_f;
  logic [5:0] sub_f;

  assign kind_f    = desc[TOP -: 2];
  assign size_f    = desc[TOP-2 -: 3];
  assign noscale_f = desc[TOP-6];
  assign nocheck_f = desc[TOP-7];
  assign sub_f     = desc[TOP-2 -: 6];
  assign bound     = desc[ADDR_W +: BOUND_W];
  assign base      = desc[ADDR_W-1:0];

  always_comb begin
    ctl            = '0;
    ctl.kind       = K_TRAP;
    unique case (kind_f)
      T_VEC, T_DD: begin
        ctl.size = (kind_f == T_DD) ? SZ_DWORD : size_f;
        if (size_legal(ctl.size)) begin
          ctl.kind      = K_VEC;
          ctl.scale_en  = !noscale_f;
          ctl.check_en  = !nocheck_f;
          ctl.align_res = (ctl.size >= SZ_WORD);
        end else begin
          ctl.size = '0;
        end
      end
      T_STR: begin
        if (size_f == SZ_BYTE) begin
          ctl.kind = K_STR;
          ctl.size = SZ_BYTE;
        end
      end
      default: begin
        if (sub_f == SUB_CODE_CHK || sub_f == SUB_CODE_FREE) begin
          ctl.kind       = K_CODE;
          ctl.size       = SZ_WORD;
          ctl.half_mod   = 1'b1;
          ctl.align_base = 1'b1;
          ctl.check_en   = (sub_f == SUB_CODE_CHK);
        end else if (sub_f == SUB_ESCAPE) begin
          ctl.kind       = K_ESC;
          ctl.size       = SZ_WORD;
          ctl.align_base = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/oam_scale.sv
module oam_scale
  import oam_pkg::*;
#(
  parameter int MOD_W = 32
) (
  input  logic [MOD_W-1:0] mod,
  input  logic [2:0]       size,
  input  logic             scale_en,
  input  logic             half_mod,
  output logic [MOD_W-1:0] offset,
  output logic [2:0]       bit_off
);
  localparam int N_SHL = 3;

  logic [MOD_W-1:0] shl [N_SHL];

  for (genvar i = 0; i < N_SHL; i++) begin : g_shl
    assign shl[i] = mod << (i + 2);
  end

  always_comb begin
    if (half_mod) begin
      offset = mod << 1;
    end else if (!scale_en) begin
      offset = mod;
    end else begin
      unique case (size)
        SZ_BIT:   offset = MOD_W'($signed(mod) >>> 3);
        SZ_WORD:  offset = shl[0];
        SZ_DWORD: offset = shl[1];
        SZ_QUAD:  offset = shl[2];
        default:  offset = mod;
      endcase
    end
    bit_off = (scale_en && !half_mod && size == SZ_BIT) ? mod[2:0] : 3'd0;
  end
endmodule

// File: rtl/oam_limit.sv
module oam_limit #(
  parameter int MOD_W   = 32,
  parameter int BOUND_W = 24
) (
  input  logic [MOD_W-1:0]   mod,
  input  logic [BOUND_W-1:0] bound,
  input  logic               check_en,
  output logic               fault
);
  logic [MOD_W-1:0] bound_ext;
  assign bound_ext = MOD_W'(bound);
  assign fault     = check_en && (mod >= bound_ext);
endmodule

// File: rtl/opnd_addr_mod.sv
module opnd_addr_mod
  import oam_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BOUND_W = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [8+BOUND_W+ADDR_W-1:0]  in_desc,
  input  logic [ADDR_W-1:0]            in_mod,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [ADDR_W-1:0]            out_addr,
  output logic [2:0]                   out_bit_off,
  output logic [2:0]                   out_size,
  output logic                         out_bound_fault,
  output logic                         out_escape,
  output logic                         out_trap
);
  ctl_t               ctl;
  logic [BOUND_W-1:0] bound;
  logic [ADDR_W-1:0]  base;
  logic [ADDR_W-1:0]  offset;
  logic [2:0]         bit_off;
  logic               fault;
  logic [ADDR_W-1:0]  base_eff;
  logic [ADDR_W-1:0]  sum;
  logic [ADDR_W-1:0]  addr_nx;
  logic               trap_nx;
  logic               accept;

  oam_decode #(.ADDR_W(ADDR_W), .BOUND_W(BOUND_W)) u_dec (
    .desc  (in_desc),
    .ctl   (ctl),
    .bound (bound),
    .base  (base)
  );

  oam_scale #(.MOD_W(ADDR_W)) u_scl (
    .mod      (in_mod),
    .size     (ctl.size),
    .scale_en (ctl.scale_en),
    .half_mod (ctl.half_mod),
    .offset   (offset),
    .bit_off  (bit_off)
  );

  oam_limit #(.MOD_W(ADDR_W), .BOUND_W(BOUND_W)) u_lim (
    .mod      (in_mod),
    .bound    (bound),
    .check_en (ctl.check_en),
    .fault    (fault)
  );

  assign trap_nx  = (ctl.kind == K_TRAP);
  assign base_eff = ctl.align_base ? {base[ADDR_W-1:2], 2'b00} : base;
  assign sum      = (ctl.kind == K_ESC) ? base_eff : base_eff + offset;

  always_comb begin
    addr_nx = sum;
    if (ctl.align_res) addr_nx[1:0] = 2'b00;
    if (trap_nx)       addr_nx = '0;
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_addr        <= '0;
      out_bit_off     <= '0;
      out_size        <= '0;
      out_bound_fault <= 1'b0;
      out_escape      <= 1'b0;
      out_trap        <= 1'b0;
    end else if (accept) begin
      out_valid       <= 1'b1;
      out_addr        <= addr_nx;
      out_bit_off     <= trap_nx ? 3'd0 : bit_off;
      out_size        <= trap_nx ? 3'd0 : ctl.size;
      out_bound_fault <= fault && !trap_nx;
      out_escape      <= (ctl.kind == K_ESC);
      out_trap        <= trap_nx;
    end else if (out_ready) begin
      out_valid       <= 1'b0;
    end
  end
endmodule

// File: rtl/oam_chk.sv
module oam_chk #(
  parameter int ADDR_W  = 32,
  parameter int BOUND_W = 24
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic [8+BOUND_W+ADDR_W-1:0] in_desc,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic [ADDR_W-1:0]           out_addr,
  input logic [2:0]                  out_bit_off,
  input logic [2:0]                  out_size,
  input logic                        out_bound_fault,
  input logic                        out_escape,
  input logic                        out_trap
);
  localparam int TOP = 8 + BOUND_W + ADDR_W - 1;

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R11

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_size)
      && $stable(out_bit_off) && $stable(out_bound_fault) && $stable(out_trap)
      && $stable(out_escape)); // R11

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R11

  AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_trap |-> out_addr == '0 && out_size == 3'd0 && out_bit_off == 3'd0); // R10

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_escape, out_trap, out_bound_fault})); // R9

  AST_BIT_OFF_ONLY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_size != 3'd0 |-> out_bit_off == 3'd0); // R3

  AST_WIDE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_desc[TOP -: 2] != 2'd3 |=>
      (out_size < 3'd5) || out_addr[1:0] == 2'b00); // R5
endmodule

bind opnd_addr_mod oam_chk #(.ADDR_W(ADDR_W), .BOUND_W(BOUND_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .in_ready        (in_ready),
  .in_desc         (in_desc),
  .out_valid       (out_valid),
  .out_ready       (out_ready),
  .out_addr        (out_addr),
  .out_bit_off     (out_bit_off),
  .out_size        (out_size),
  .out_bound_fault (out_bound_fault),
  .out_escape      (out_escape),
  .out_trap        (out_trap)
);

// File: tb/tb_opnd_addr_mod.sv
module tb_opnd_addr_mod;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_desc = '0;
  logic [31:0] in_mod = '0;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_addr;
  logic [2:0]  out_bit_off;
  logic [2:0]  out_size;
  logic        out_bound_fault;
  logic        out_escape;
  logic        out_trap;

  int checks = 0;
  int fails = 0;
  int ready_mode = 1;
  string cur_tag = "R1";

  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  boff;
    logic [2:0]  sz;
    logic        flt;
    logic        esc;
    logic        trp;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];

  always #4 clk = ~clk;

  opnd_addr_mod dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_desc(in_desc), .in_mod(in_mod), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_bit_off(out_bit_off),
    .out_size(out_size), .out_bound_fault(out_bound_fault),
    .out_escape(out_escape), .out_trap(out_trap)
  );

  always @(posedge clk) begin
    #1;
    if (ready_mode == 2) out_ready = ($urandom % 4) != 0;
    else out_ready = (ready_mode == 1);
  end
  initial out_ready = 1'b1;

  function automatic logic [63:0] mk(input logic [1:0] t, input logic [2:0] sz,
                                     input logic usc, input logic bci,
                                     input logic [23:0] bnd, input logic [31:0] base);
    return {t, sz, 1'b0, usc, bci, bnd, base};
  endfunction

  function automatic logic [63:0] mk3(input logic [5:0] sub, input logic [23:0] bnd,
                                      input logic [31:0] base);
    return {2'b11, sub, bnd, base};
  endfunction

  function automatic exp_t model(input logic [63:0] d, input logic [31:0] m);
    exp_t e;
    logic [1:0]  t;
    logic [2:0]  sz;
    logic [5:0]  sub;
    logic [31:0] base;
    logic [31:0] bnd;
    logic [31:0] off;
    e    = '0;
    t    = d[63:62];
    sz   = d[61:59];
    sub  = d[61:56];
    base = d[31:0];
    bnd  = {8'd0, d[55:32]};
    if (t == 2'd0 || t == 2'd2) begin
      if (t == 2'd2) sz = 3'd6;
      if (sz == 3'd1 || sz == 3'd2 || sz == 3'd4) begin
        e.trp = 1'b1;
      end else begin
        e.sz  = sz;
        e.flt = !d[56] && (m >= bnd);
        off   = m;
        if (!d[57]) begin
          case (sz)
            3'd0: begin off = $signed(m) >>> 3; e.boff = m[2:0]; end
            3'd5: off = m * 4;
            3'd6: off = m * 8;
            3'd7: off = m * 16;
            default: off = m;
          endcase
        end
        e.addr = base + off;
        if (sz >= 3'd5) e.addr = e.addr & ~32'd3;
      end
    end else if (t == 2'd1) begin
      if (sz != 3'd3) e.trp = 1'b1;
      else begin e.sz = 3'd3; e.addr = base + m; end
    end else begin
      if (sub == 6'd32 || sub == 6'd34) begin
        e.sz   = 3'd5;
        e.addr = (base & ~32'd3) + m * 2;
        e.flt  = (sub == 6'd32) && (m >= bnd);
      end else if (sub == 6'd37) begin
        e.sz   = 3'd5;
        e.esc  = 1'b1;
        e.addr = base & ~32'd3;
      end else begin
        e.trp = 1'b1;
      end
    end
    return e;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference comparison, every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R11", "out_valid", {31'd0, out_valid}, {31'd0, expq.size() != 0});
      if (out_valid && expq.size() != 0) begin
        chk(tagq[0], "addr", out_addr, expq[0].addr);
        chk(tagq[0], "bit_off", {29'd0, out_bit_off}, {29'd0, expq[0].boff});
        chk(tagq[0], "size", {29'd0, out_size}, {29'd0, expq[0].sz});
        chk(tagq[0], "fault", {31'd0, out_bound_fault}, {31'd0, expq[0].flt});
        chk(tagq[0], "escape", {31'd0, out_escape}, {31'd0, expq[0].esc});
        chk(tagq[0], "trap", {31'd0, out_trap}, {31'd0, expq[0].trp});
        if (out_ready) begin
          void'(expq.pop_front());
          void'(tagq.pop_front());
        end
      end
      chk("R11", "in_ready", {31'd0, in_ready}, {31'd0, !out_valid || out_ready});
      if (in_valid && in_ready) begin
        expq.push_back(model(in_desc, in_mod));
        tagq.push_back(cur_tag);
      end
    end
  end

  task automatic send(input string tag, input logic [63:0] d, input logic [31:0] m);
    cur_tag  = tag;
    in_desc  = d;
    in_mod   = m;
    in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R12", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R12", "in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R12", "out_valid after reset", {31'd0, out_valid}, 32'd0);

    send("R1", mk(0, 3, 1, 1, 24'd0, 32'h1000), 32'd5);
    send("R2", mk(0, 5, 0, 1, 24'd0, 32'h2001), 32'd3);
    send("R2", mk(0, 6, 0, 1, 24'd0, 32'h3000), 32'd2);
    send("R2", mk(0, 7, 0, 1, 24'd0, 32'h3000), 32'd1);
    send("R3", mk(0, 0, 0, 1, 24'd0, 32'h100), 32'h1D);
    send("R3", mk(0, 0, 0, 1, 24'd0, 32'h100), 32'hFFFF_FFF7);
    send("R4", mk(0, 3, 0, 0, 24'd10, 32'h40), 32'd9);
    send("R4", mk(0, 3, 0, 0, 24'd10, 32'h40), 32'd10);
    send("R4", mk(0, 3, 0, 0, 24'd10, 32'h40), 32'hFFFF_FFFF);
    send("R4", mk(0, 3, 0, 1, 24'd10, 32'h40), 32'd100);
    send("R4", mk(0, 5, 0, 0, 24'd4, 32'h40), 32'd3);
    send("R5", mk(0, 7, 1, 1, 24'd0, 32'h13), 32'd2);
    send("R6", mk(1, 3, 1, 0, 24'd2, 32'h800), 32'd50);
    send("R6", mk(1, 5, 0, 0, 24'd2, 32'h800), 32'd1);
    send("R7", mk(2, 0, 0, 0, 24'd8, 32'h400), 32'd7);
    send("R7", mk(2, 0, 0, 0, 24'd8, 32'h400), 32'd8);
    send("R8", mk3(6'd32, 24'd6, 32'h503), 32'd5);
    send("R8", mk3(6'd32, 24'd6, 32'h503), 32'd6);
    send("R8", mk3(6'd34, 24'd0, 32'h500), 32'hFFFF_FFFE);
    send("R9", mk3(6'd37, 24'd0, 32'h7777), 32'd9);
    send("R10", mk3(6'd35, 24'd5, 32'h900), 32'd1);
    send("R10", mk3(6'd36, 24'd5, 32'h900), 32'd1);
    send("R10", mk(0, 4, 0, 0, 24'd5, 32'h900), 32'd1);

    // stall: hold output, then release
    ready_mode = 0;
    @(posedge clk); #1;
    send("R11", mk(0, 6, 0, 1, 24'd0, 32'hA00), 32'd3);
    in_desc  = mk(0, 3, 1, 1, 24'd0, 32'hB00);
    in_mod   = 32'd1;
    cur_tag  = "R11";
    in_valid = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    ready_mode = 1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;

    // mixed traffic with random back-pressure
    ready_mode = 2;
    for (int i = 0; i < 400; i++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      d[55:32] = 24'($urandom % 64);
      send("R2", d, ($urandom % 3 == 0) ? $urandom : 32'($urandom % 80));
    end
    ready_mode = 1;
    repeat (4) @(posedge clk);
    #1;
    chk("R11", "queue drained", expq.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule